// File: doc/BRIEF.md
# Interpolate-by-3 Pulse-Shaping Filter

This block takes complex chip-rate samples (16-bit I and Q, two's complement) and produces three filtered complex samples for every chip accepted, so the output rate is three times the chip rate. In the intended system the chip rate is 1.28 MS/s on a 92.16 MHz master clock, which leaves 72 clocks per chip. The filter is a 36-tap polyphase structure. Output phase p of chip n uses the coefficients h[3k+p] for k = 0..11 against the twelve most recent chips. The coefficient set is meant to carry a root-raised-cosine response with roll-off 0.22, plus passband pre-emphasis for the droop of the integrator-comb stages that follow. Coefficient design is outside this block.

A single multiply-accumulate unit is shared across all the work. Each output phase takes 12 MACs for I and then 12 for Q, which is 24 clocks, so the three phases exactly fill the 72-clock budget. Coefficients are written by address into a shadow bank. The shadow bank is copied into the working bank when a chip is accepted, so the set in use never changes in the middle of a chip.

The controller has three states. `ST_IDLE` waits for a chip. `ST_RUN_I` accumulates the in-phase sum of the current phase. `ST_RUN_Q` accumulates the quadrature sum and, on its last tap, presents the output pair. The transitions are:
- *start*: `ST_IDLE` to `ST_RUN_I` when a chip is accepted.
- *i_done*: `ST_RUN_I` to `ST_RUN_Q` after tap 11.
- *next_phase*: `ST_RUN_Q` to `ST_RUN_I` after tap 11 of phase 0 or 1.
- *chain*: `ST_RUN_Q` to `ST_RUN_I` after tap 11 of phase 2 when a new chip is offered in that same cycle.
- *finish*: `ST_RUN_Q` to `ST_IDLE` after tap 11 of phase 2 when no chip is offered.

Top module: `interp3_shaper`

## Requirements
- R1: A chip is accepted on `in_valid` when the block is in `ST_IDLE` or in the final compute cycle (phase 2, Q, tap 11). A chip offered every 72 clocks is therefore accepted every time, and every accepted chip yields exactly three output pulses.
- R2: The outputs of a chip come in phase order 0, 1, 2. Phase p equals the sum over k = 0..11 of h[3k+p]·x[n−k], where x[n] is the chip just accepted.
- R3: The I and Q paths are filtered independently with the same coefficients. `out_i` depends only on I inputs and `out_q` only on Q inputs.
- R4: Coefficients are signed with 15 fractional bits. The full-precision sum is rounded as (sum + 2^14) >> 15 (arithmetic shift), so exact halves round toward +∞. The accumulator never wraps.
- R5: A rounded result is saturated to the range −32768..32767.
- R6: `out_valid` is a one-cycle pulse. For a chip accepted at clock edge e, the three pulses are registered at edges e+24, e+48 and e+72.
- R7: `cw_en` writes `cw_data` (signed 16-bit) to coefficient `cw_addr` (0..35). A write takes effect from the next accepted chip. A write made while a chip is being computed does not alter that chip's outputs.
- R8: An `in_valid` that arrives while the block is busy and not in its final cycle is dropped: the sample history is unchanged. The `overflow` output then goes high and stays high until reset.
- R9: After reset, `out_valid`, `out_i`, `out_q` and `overflow` are 0, and the sample history and both coefficient banks are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Chip strobe |
| in_i | input | 16 | In-phase chip sample |
| in_q | input | 16 | Quadrature chip sample |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 6 | Coefficient index, 0..35 |
| cw_data | input | 16 | Signed coefficient value, 15 fractional bits |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Filtered in-phase output |
| out_q | output | 16 | Filtered quadrature output |
| overflow | output | 1 | Sticky flag set when a chip is dropped |

## Verification
The assertions assume that coefficient writes use only addresses 0..35, and the bench only ever writes within that range. The no-wrap check on the accumulator assumes that at most twelve full-scale products are summed per result, which the fixed taps-per-phase count guarantees. The bench offers chips either at the exact 72-clock cadence or with extra idle gaps. It creates a busy-time collision only once, on purpose, in the drop scenario. It never offers a coefficient write in the same cycle as an accepted chip.

// File: rtl/interp3_pkg.sv
`timescale 1ns/1ps
package interp3_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN_I = 2'd1,
        ST_RUN_Q = 2'd2
    } shaper_state_t;
endpackage

// File: rtl/interp3_coefs.sv
`timescale 1ns/1ps
module interp3_coefs #(
    parameter int NTAPS  = 36,
    parameter int COEF_W = 16,
    parameter int AW     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic                     load,
    input  logic [AW-1:0]            rd_addr,
    output logic signed [COEF_W-1:0] rd_data
);
    logic signed [COEF_W-1:0] shadow [NTAPS];
    logic signed [COEF_W-1:0] active [NTAPS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NTAPS; j++) begin
                shadow[j] <= '0;
                active[j] <= '0;
            end
        end else begin
            if (wr_en && (int'(wr_addr) < NTAPS))
                shadow[wr_addr] <= wr_data;
            if (load)
                for (int j = 0; j < NTAPS; j++)
                    active[j] <= shadow[j];
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NTAPS)
            rd_data = active[rd_addr];
    end

    AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NTAPS)); // R7
    AST_RD_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) < NTAPS)); // R2
endmodule

// File: rtl/interp3_taps.sv
`timescale 1ns/1ps
module interp3_taps #(
    parameter int DEPTH  = 12,
    parameter int DATA_W = 16,
    parameter int KW     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift,
    input  logic signed [DATA_W-1:0] new_i,
    input  logic signed [DATA_W-1:0] new_q,
    input  logic [KW-1:0]            sel,
    output logic signed [DATA_W-1:0] tap_i,
    output logic signed [DATA_W-1:0] tap_q
);
    logic signed [DATA_W-1:0] line_i [DEPTH];
    logic signed [DATA_W-1:0] line_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                line_i[j] <= '0;
                line_q[j] <= '0;
            end
        end else if (shift) begin
            line_i[0] <= new_i;
            line_q[0] <= new_q;
            for (int j = 1; j < DEPTH; j++) begin
                line_i[j] <= line_i[j-1];
                line_q[j] <= line_q[j-1];
            end
        end
    end

    always_comb begin
        tap_i = '0;
        tap_q = '0;
        if (int'(sel) < DEPTH) begin
            tap_i = line_i[sel];
            tap_q = line_q[sel];
        end
    end

    AST_HISTORY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(line_i[DEPTH-1]) && $stable(line_q[0])); // R8
    AST_NEWEST_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (line_i[0] == $past(new_i)) && (line_q[0] == $past(new_q))); // R1
endmodule

// File: rtl/interp3_mac.sv
`timescale 1ns/1ps
module interp3_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 40,
    parameter int FRAC_W = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     first,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [DATA_W-1:0] smp,
    output logic signed [DATA_W-1:0] result
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W-1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (DATA_W-1));
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W-1);

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_x, acc, sum_now, biased, shifted;

    always_comb begin
        prod    = coef * smp;
        prod_x  = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        sum_now = (first ? '0 : acc) + prod_x;
        biased  = sum_now + HALF;
        shifted = biased >>> FRAC_W;
        if (shifted > MAXV)
            result = MAXV[DATA_W-1:0];
        else if (shifted < MINV)
            result = MINV[DATA_W-1:0];
        else
            result = shifted[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (en)
            acc <= sum_now;
    end

    AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !first && (acc[ACC_W-1] == prod_x[ACC_W-1]))
            |-> (sum_now[ACC_W-1] == acc[ACC_W-1])); // R4
endmodule

// File: rtl/interp3_shaper.sv
`timescale 1ns/1ps
module interp3_shaper #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NTAPS  = 36,
    parameter int FACTOR = 3,
    parameter int ACC_W  = 40,
    parameter int FRAC_W = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic                     cw_en,
    input  logic [5:0]               cw_addr,
    input  logic signed [COEF_W-1:0] cw_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q,
    output logic                     overflow
);
    import interp3_pkg::*;

    localparam int TPP = NTAPS / FACTOR;
    localparam int KW  = $clog2(TPP);
    localparam int PW  = $clog2(FACTOR);
    localparam int AW  = 6;

    shaper_state_t state, nstate;
    logic [KW-1:0] k;
    logic [PW-1:0] phase;
    logic last_tap, last_phase, fin, busy, accept, drop;
    logic [AW-1:0] coef_addr;
    logic signed [COEF_W-1:0] coef;
    logic signed [DATA_W-1:0] tap_i, tap_q, smp, mac_res, hold_i;

    assign last_tap   = (k == KW'(TPP-1));
    assign last_phase = (phase == PW'(FACTOR-1));
    assign fin        = (state == ST_RUN_Q) && last_tap && last_phase;
    assign busy       = (state != ST_IDLE) && !fin;
    assign accept     = in_valid && !busy;
    assign drop       = in_valid && busy;
    assign coef_addr  = AW'(FACTOR * int'(k) + int'(phase));
    assign smp        = (state == ST_RUN_Q) ? tap_q : tap_i;

    interp3_coefs #(.NTAPS(NTAPS), .COEF_W(COEF_W), .AW(AW)) u_coefs (
        .clk(clk), .rst_n(rst_n), .wr_en(cw_en), .wr_addr(cw_addr),
        .wr_data(cw_data), .load(accept), .rd_addr(coef_addr), .rd_data(coef)
    );

    interp3_taps #(.DEPTH(TPP), .DATA_W(DATA_W), .KW(KW)) u_taps (
        .clk(clk), .rst_n(rst_n), .shift(accept), .new_i(in_i), .new_q(in_q),
        .sel(k), .tap_i(tap_i), .tap_q(tap_q)
    );

    interp3_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .en(state != ST_IDLE), .first(k == '0),
        .coef(coef), .smp(smp), .result(mac_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions: start, i_done, next_phase, chain, finish
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (accept) nstate = ST_RUN_I;
            ST_RUN_I: if (last_tap) nstate = ST_RUN_Q;
            ST_RUN_Q: if (last_tap) begin
                if (!last_phase)  nstate = ST_RUN_I;
                else if (accept)  nstate = ST_RUN_I;
                else              nstate = ST_IDLE;
            end
            default:  nstate = ST_IDLE;
        endcase
    end

    // counters and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k         <= '0;
            phase     <= '0;
            hold_i    <= '0;
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (drop) overflow <= 1'b1;
            unique case (state)
                ST_IDLE: ;
                ST_RUN_I: begin
                    k <= last_tap ? '0 : k + KW'(1);
                    if (last_tap) hold_i <= mac_res;
                end
                ST_RUN_Q: begin
                    k <= last_tap ? '0 : k + KW'(1);
                    if (last_tap) begin
                        out_i     <= hold_i;
                        out_q     <= mac_res;
                        out_valid <= 1'b1;
                        phase     <= last_phase ? '0 : phase + PW'(1);
                    end
                end
                default: ;
            endcase
            if (accept) begin
                k     <= '0;
                phase <= '0;
            end
        end
    end

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6
    AST_STROBE_FROM_Q: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(state) == ST_RUN_Q)); // R6
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> overflow); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8
    AST_CLEAN_START: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_RUN_I) && (k == '0) && (phase == '0)); // R1
    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase <= PW'(FACTOR-1))); // R2
endmodule

// File: tb/interp3_shaper_test.sv
`timescale 1ns/1ps
module interp3_shaper_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic cw_en = 1'b0;
    logic [5:0] cw_addr = '0;
    logic signed [15:0] cw_data = '0;
    logic out_valid, overflow;
    logic signed [15:0] out_i, out_q;

    always #2 clk = ~clk;

    interp3_shaper uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .overflow(overflow)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int sh[36];
    int hist_i[12], hist_q[12];
    int exp_i[512], exp_q[512], exp_t[512];
    string exp_tag[512];
    int wr = 0, rd = 0;

    function automatic int rsat(longint s);
        longint r = (s + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(input string tag, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // monitor: compare every output strobe against the model queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd >= wr) begin
                checks++; fails++;
                $display("FAIL R1 unexpected output: actual %0d/%0d expected none", out_i, out_q);
            end else begin
                check(exp_tag[rd], int'(out_i), exp_i[rd], "out_i");
                check(exp_tag[rd], int'(out_q), exp_q[rd], "out_q");
                check("R6", cyc, exp_t[rd], "strobe cycle");
                rd++;
            end
        end
    end

    task automatic model_chip(input int vi, input int vq, input int t, input string tag);
        int act[36];
        for (int j = 0; j < 36; j++) act[j] = sh[j];
        for (int j = 11; j > 0; j--) begin
            hist_i[j] = hist_i[j-1];
            hist_q[j] = hist_q[j-1];
        end
        hist_i[0] = vi; hist_q[0] = vq;
        for (int p = 0; p < 3; p++) begin
            longint si = 0, sq = 0;
            for (int k = 0; k < 12; k++) begin
                si += longint'(act[3*k+p]) * longint'(hist_i[k]);
                sq += longint'(act[3*k+p]) * longint'(hist_q[k]);
            end
            exp_i[wr] = rsat(si); exp_q[wr] = rsat(sq);
            exp_t[wr] = t + 24*(p+1); exp_tag[wr] = tag;
            wr++;
        end
    endtask

    task automatic send_chip(input int vi, input int vq, input string tag, input int gap);
        @(negedge clk);
        in_valid = 1'b1; in_i = 16'(vi); in_q = 16'(vq);
        @(posedge clk); #1;
        model_chip(vi, vq, cyc, tag);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (70 + gap) @(negedge clk);
    endtask

    task automatic wr_coef(input int a, input int v);
        @(negedge clk);
        cw_en = 1'b1; cw_addr = 6'(a); cw_data = 16'(v);
        sh[a] = v;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic drain();
        repeat (90) @(negedge clk);
        check("R1", wr - rd, 0, "outputs outstanding");
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9", int'(out_valid), 0, "out_valid after reset");
        check("R9", int'(overflow), 0, "overflow after reset");
        check("R9", int'(out_i), 0, "out_i after reset");
        check("R9", int'(out_q), 0, "out_q after reset");
        send_chip(1234, -4321, "R9", 0);
        drain();
    endtask

    task automatic t_impulse_ramp();
        for (int j = 0; j < 36; j++) wr_coef(j, (j < 3) ? 32767 : 0);
        for (int n = 0; n < 14; n++) send_chip(100*n - 300, -50*n + 7, "R2", 0);
        drain();
    endtask

    task automatic t_general();
        for (int j = 0; j < 36; j++) wr_coef(j, ((j * 1237) % 4001) - 2000);
        for (int n = 0; n < 14; n++)
            send_chip((n * 2917) % 20000 - 10000, 15000 - (n * 3331) % 30000, "R3", n % 2);
        drain();
    endtask

    task automatic t_rounding();
        for (int j = 0; j < 36; j++) wr_coef(j, (j == 0) ? 16384 : 0);
        send_chip(1, -1, "R4", 0);
        send_chip(3, -3, "R4", 0);
        send_chip(-2, 2, "R4", 0);
        drain();
    endtask

    task automatic t_saturate();
        for (int j = 0; j < 36; j++) wr_coef(j, 32767);
        for (int n = 0; n < 13; n++) send_chip(32767, -32768, "R5", 0);
        drain();
    endtask

    task automatic t_coef_update();
        for (int j = 0; j < 36; j++) wr_coef(j, 500 * (j % 7) - 1500);
        send_chip(800, -900, "R7", 0);
        fork
            send_chip(2000, 3000, "R7", 0);
            begin
                repeat (10) @(negedge clk);
                wr_coef(0, 20000);
                wr_coef(1, -20000);
                wr_coef(2, 12345);
            end
        join
        send_chip(-700, 600, "R7", 0);
        drain();
    endtask

    task automatic t_drop();
        @(negedge clk);
        check("R8", int'(overflow), 0, "overflow before collision");
        fork
            send_chip(4000, -4000, "R8", 0);
            begin
                repeat (6) @(negedge clk);
                in_valid = 1'b1; in_i = 16'sd999; in_q = -16'sd999;
                @(negedge clk);
                in_valid = 1'b0;
            end
        join
        check("R8", int'(overflow), 1, "overflow after collision");
        send_chip(-1000, 2500, "R8", 0);
        drain();
        check("R8", int'(overflow), 1, "overflow stays set");
    endtask

    initial begin
        for (int j = 0; j < 36; j++) sh[j] = 0;
        for (int j = 0; j < 12; j++) begin hist_i[j] = 0; hist_q[j] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_impulse_ramp();
        t_general();
        t_rounding();
        t_saturate();
        t_coef_update();
        t_drop();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule